// File: doc/BRIEF.md
# SPI Receive Status and Overrun Tracker

This block keeps the receive-side status that a CPU sees for an SPI peripheral. A shift engine hands it a one-cycle "byte complete" strobe together with the received byte. The block holds that byte in a receive data register and raises a receive-full flag. If a further byte completes while the earlier one is still unread, the block raises an overrun flag and drops the new byte. The held byte is kept.

Software clears a flag with a two-step access. First it reads the status register while the flag is set. Then it reads the data register. An armed bit inside each flag remembers the first step. Any fresh set event between the two reads throws that memory away, so an old sequence cannot clear a newer event. Both flags and an external mode-fault input drive one shared interrupt request. A receive enable gates the receive-full flag onto the request. A single error enable gates overrun and mode fault together.

Top module: `spi_rx_status`

## Requirements
- R1: A `rx_done` pulse that is accepted loads `rx_byte` into `data_q` and sets the receive-full flag at `stat_q` bit 0 after the next clock edge. The data register changes on no other event.
- R2: The receive-full flag stays set across data reads until the CPU has done a status read while the flag was set and then a data read. A data read with no such status read before it has no effect.
- R3: A `rx_done` pulse that arrives while receive-full is set and is not being cleared in the same cycle sets the overrun flag at `stat_q` bit 1. The byte is discarded and `data_q` keeps its earlier value.
- R4: The overrun flag clears only after a status read while it was set, followed by a data read. The same data read may clear receive-full and overrun together.
- R5: A new set event on a flag after the status read cancels that read. The next data read then leaves the flag set until another status read is done.
- R6: When a byte completes in the same cycle as a data read that clears receive-full, the byte is accepted and loaded. Receive-full stays set and overrun does not set.
- R7: `irq` is high exactly when (`rx_ie` and receive-full) or (`err_ie` and (overrun or `modf_in`)). Overrun cannot be enabled separately from mode fault.
- R8: `stat_q` bit 2 shows the `modf_in` input. All other `stat_q` bits above bit 2 read zero.
- R9: While reset is active, both flags and the data register are zero and `irq` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| rx_done | input | 1 | One-cycle strobe: a received byte is complete |
| rx_byte | input | DATA_W | Byte from the shift engine, valid with rx_done |
| stat_rd | input | 1 | CPU read strobe on the status register |
| data_rd | input | 1 | CPU read strobe on the data register |
| rx_ie | input | 1 | Receive-full interrupt enable |
| err_ie | input | 1 | Error (overrun and mode fault) interrupt enable |
| modf_in | input | 1 | Mode-fault flag from the mode logic |
| stat_q | output | STAT_W | Status read value: bit 0 full, bit 1 overrun, bit 2 mode fault |
| data_q | output | DATA_W | Receive data register |
| irq | output | 1 | Shared receive/error interrupt request |

## Verification
The bench checks that a data read with no status read before it leaves receive-full set. A design that cleared on the data read alone would lose that flag at once. It sends a second byte while the first is unread and checks that the first byte survives. A design that overwrote the register would show the newer value. It places a new overrun between a status read and a data read and expects overrun to survive the data read. It also sends a byte in the same cycle as a clearing data read and expects the byte to load with no overrun. A design that favoured the clear, or counted that byte as an overrun, would show an empty flag or a stale byte. The interrupt enables are walked one at a time against each source, so a wrongly gated source shows up as a wrong `irq` level.

// File: rtl/spi_rx_pkg.sv
// Shared constants for the SPI receive status tracker.
// Assumes a status word of at least three bits.
package spi_rx_pkg;
    localparam int FULL_BIT = 0;  // receive-full flag position
    localparam int OVR_BIT  = 1;  // overrun flag position
    localparam int MF_BIT   = 2;  // mode-fault mirror position
    localparam int USED_W   = 3;  // status bits in use
endpackage

// File: rtl/spi_rx_flag.sv
// One status flag with a two-step clear.
// A status read that sees the flag set arms the flag. A later data read
// clears an armed flag. A set event always wins, and it disarms the flag.
// Assumes the strobes are single-cycle and synchronous to clk.
module spi_rx_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic set_ev,
    input  logic stat_rd,
    input  logic data_rd,
    output logic flag_q,
    output logic clr_hit
);
    logic armed_q;

    // A clear is due when the data read comes after an armed status read.
    assign clr_hit = data_rd & armed_q;

    // Flag and armed-bit update: set wins, then clear, then arm.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag_q  <= 1'b0;
            armed_q <= 1'b0;
        end else if (set_ev) begin
            flag_q  <= 1'b1;
            armed_q <= 1'b0;
        end else if (clr_hit) begin
            flag_q  <= 1'b0;
            armed_q <= 1'b0;
        end else if (stat_rd && flag_q) begin
            armed_q <= 1'b1;
        end
    end
endmodule

// File: rtl/spi_rx_hold.sv
// Receive data holding register. It loads only on an accepted byte.
// Assumes the load strobe is already gated by the overrun logic.
module spi_rx_hold #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] dout
);
    // Hold register: cleared by reset, written on load.
    always_ff @(posedge clk) begin
        if (!rst_n)
            dout <= '0;
        else if (load)
            dout <= din;
    end
endmodule

// File: rtl/spi_rx_irq.sv
// Shared interrupt request. The receive enable gates the full flag.
// One error enable gates overrun and mode fault together.
// Assumes the inputs are registered flags or steady control bits.
module spi_rx_irq (
    input  logic full,
    input  logic ovr,
    input  logic modf,
    input  logic rx_ie,
    input  logic err_ie,
    output logic irq
);
    // OR of the enabled sources.
    always_comb begin
        irq = (rx_ie & full) | (err_ie & (ovr | modf));
    end
endmodule

// File: rtl/spi_rx_status.sv
// SPI receive status tracker: holds the receive data register, the
// receive-full and overrun flags, and the shared receive/error request.
// Assumes rx_done, stat_rd and data_rd are single-cycle strobes and that
// modf_in comes from a flag already registered elsewhere.
module spi_rx_status
    import spi_rx_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int STAT_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_done,
    input  logic [DATA_W-1:0] rx_byte,
    input  logic              stat_rd,
    input  logic              data_rd,
    input  logic              rx_ie,
    input  logic              err_ie,
    input  logic              modf_in,
    output logic [STAT_W-1:0] stat_q,
    output logic [DATA_W-1:0] data_q,
    output logic              irq
);
    localparam int PAD_W = STAT_W - USED_W;

    logic full_q, full_clr;
    logic ovr_q, ovr_clr;
    logic accept, overrun;

    // A byte is taken when the holder is empty or is being emptied now.
    assign accept  = rx_done & (~full_q | full_clr);
    assign overrun = rx_done & ~accept;

    spi_rx_flag full_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_ev  (accept),
        .stat_rd (stat_rd),
        .data_rd (data_rd),
        .flag_q  (full_q),
        .clr_hit (full_clr)
    );

    spi_rx_flag ovr_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_ev  (overrun),
        .stat_rd (stat_rd),
        .data_rd (data_rd),
        .flag_q  (ovr_q),
        .clr_hit (ovr_clr)
    );

    spi_rx_hold #(.DATA_W(DATA_W)) hold_i (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (accept),
        .din   (rx_byte),
        .dout  (data_q)
    );

    spi_rx_irq irq_i (
        .full   (full_q),
        .ovr    (ovr_q),
        .modf   (modf_in),
        .rx_ie  (rx_ie),
        .err_ie (err_ie),
        .irq    (irq)
    );

    // Status read value: the flags and the mode-fault mirror, upper bits zero.
    generate
        if (PAD_W > 0) begin : g_pad
            assign stat_q[STAT_W-1:USED_W] = '0;
        end
    endgenerate
    assign stat_q[FULL_BIT] = full_q;
    assign stat_q[OVR_BIT]  = ovr_q;
    assign stat_q[MF_BIT]   = modf_in;
endmodule

// File: rtl/spi_rx_status_chk.sv
// Property checker for spi_rx_status, attached through bind.
// It watches the ports only.
module spi_rx_status_chk
    import spi_rx_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int STAT_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              rx_done,
    input logic [DATA_W-1:0] rx_byte,
    input logic              data_rd,
    input logic              rx_ie,
    input logic              err_ie,
    input logic [STAT_W-1:0] stat_q,
    input logic [DATA_W-1:0] data_q,
    input logic              irq
);
    // An accepted byte on an empty holder is loaded and marks the holder full.
    assert_load_R1: assert property (@(posedge clk) disable iff (!rst_n)
        rx_done && !stat_q[FULL_BIT] |=> stat_q[FULL_BIT] && data_q == $past(rx_byte));

    // With no byte arriving, the data register does not move.
    assert_quiet_data_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_done |=> $stable(data_q));

    // Receive-full never drops without a data read.
    assert_full_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        stat_q[FULL_BIT] && !data_rd |=> stat_q[FULL_BIT]);

    // A byte onto a full holder with no read is dropped and flags overrun.
    assert_drop_R3: assert property (@(posedge clk) disable iff (!rst_n)
        rx_done && stat_q[FULL_BIT] && !data_rd |=> stat_q[OVR_BIT] && $stable(data_q));

    // Overrun never drops without a data read.
    assert_ovr_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        stat_q[OVR_BIT] && !data_rd |=> stat_q[OVR_BIT]);

    // With both enables off, no request is raised.
    assert_no_irq_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_ie && !err_ie |-> !irq);

    // An enabled overrun always raises the request.
    assert_err_irq_R7: assert property (@(posedge clk) disable iff (!rst_n)
        err_ie && stat_q[OVR_BIT] |-> irq);
endmodule

bind spi_rx_status spi_rx_status_chk #(.DATA_W(DATA_W), .STAT_W(STAT_W)) chk_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .rx_done (rx_done),
    .rx_byte (rx_byte),
    .data_rd (data_rd),
    .rx_ie   (rx_ie),
    .err_ie  (err_ie),
    .stat_q  (stat_q),
    .data_q  (data_q),
    .irq     (irq)
);

// File: tb/spi_rx_status_tb.sv
// Bench for spi_rx_status: a vector table walked by one loop, then directed reset checks.
module spi_rx_status_tb_top;
    localparam int DATA_W = 8;
    localparam int STAT_W = 8;
    localparam int NV     = 28;
    // Vector fields: [29:26] req, [25] rx_done, [24:17] byte, [16] stat_rd,
    // [15] data_rd, [14] rx_ie, [13] err_ie, [12] modf, [11:9] expected
    // status bits {mf,ovr,full}, [8:1] expected data, [0] expected irq.
    localparam logic [29:0] VEC [NV] = '{
        {4'd1, 1'b1, 8'hA5, 5'b00000, 3'b001, 8'hA5, 1'b0}, // R1 load
        {4'd2, 1'b0, 8'h00, 5'b01000, 3'b001, 8'hA5, 1'b0}, // R2 bare data read
        {4'd2, 1'b0, 8'h00, 5'b10000, 3'b001, 8'hA5, 1'b0}, // R2 status read arms
        {4'd2, 1'b0, 8'h00, 5'b01000, 3'b000, 8'hA5, 1'b0}, // R2 data read clears
        {4'd1, 1'b1, 8'h3C, 5'b00000, 3'b001, 8'h3C, 1'b0}, // R1 second byte
        {4'd3, 1'b1, 8'h77, 5'b00000, 3'b011, 8'h3C, 1'b0}, // R3 overrun drops byte
        {4'd4, 1'b0, 8'h00, 5'b10000, 3'b011, 8'h3C, 1'b0}, // R4 arm both
        {4'd4, 1'b0, 8'h00, 5'b01000, 3'b000, 8'h3C, 1'b0}, // R4 clear both
        {4'd1, 1'b1, 8'h11, 5'b00000, 3'b001, 8'h11, 1'b0}, // R1
        {4'd6, 1'b0, 8'h00, 5'b10000, 3'b001, 8'h11, 1'b0}, // R6 arm full
        {4'd6, 1'b1, 8'h22, 5'b01000, 3'b001, 8'h22, 1'b0}, // R6 byte with clearing read
        {4'd5, 1'b0, 8'h00, 5'b01000, 3'b001, 8'h22, 1'b0}, // R5 set disarmed full
        {4'd2, 1'b0, 8'h00, 5'b10000, 3'b001, 8'h22, 1'b0}, // R2 re-arm
        {4'd2, 1'b0, 8'h00, 5'b01000, 3'b000, 8'h22, 1'b0}, // R2 clear
        {4'd1, 1'b1, 8'h44, 5'b00000, 3'b001, 8'h44, 1'b0}, // R1
        {4'd3, 1'b1, 8'h55, 5'b00000, 3'b011, 8'h44, 1'b0}, // R3
        {4'd5, 1'b0, 8'h00, 5'b10000, 3'b011, 8'h44, 1'b0}, // R5 arm both
        {4'd5, 1'b1, 8'h66, 5'b00000, 3'b011, 8'h44, 1'b0}, // R5 new overrun disarms it
        {4'd5, 1'b0, 8'h00, 5'b01000, 3'b010, 8'h44, 1'b0}, // R5 overrun survives
        {4'd4, 1'b0, 8'h00, 5'b10000, 3'b010, 8'h44, 1'b0}, // R4 arm overrun
        {4'd4, 1'b0, 8'h00, 5'b01000, 3'b000, 8'h44, 1'b0}, // R4 clear overrun
        {4'd7, 1'b0, 8'h00, 5'b00100, 3'b000, 8'h44, 1'b0}, // R7 enable, no source
        {4'd7, 1'b1, 8'h99, 5'b00100, 3'b001, 8'h99, 1'b1}, // R7 full with rx_ie
        {4'd8, 1'b0, 8'h00, 5'b00001, 3'b101, 8'h99, 1'b0}, // R8 mode fault mirror
        {4'd7, 1'b0, 8'h00, 5'b00011, 3'b101, 8'h99, 1'b1}, // R7 mode fault with err_ie
        {4'd7, 1'b0, 8'h00, 5'b00010, 3'b001, 8'h99, 1'b0}, // R7 full without rx_ie
        {4'd7, 1'b1, 8'h12, 5'b00010, 3'b011, 8'h99, 1'b1}, // R7 overrun with err_ie
        {4'd7, 1'b0, 8'h00, 5'b00000, 3'b011, 8'h99, 1'b0}  // R7 all enables off
    };

    logic              clk = 1'b0;
    logic              rst_n;
    logic              rx_done, stat_rd, data_rd, rx_ie, err_ie, modf_in;
    logic [DATA_W-1:0] rx_byte;
    logic [STAT_W-1:0] stat_q;
    logic [DATA_W-1:0] data_q;
    logic              irq;
    int                total = 0;
    int                bad = 0;
    bit                done = 1'b0;

    always #4 clk = ~clk;

    spi_rx_status #(.DATA_W(DATA_W), .STAT_W(STAT_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .rx_done(rx_done), .rx_byte(rx_byte),
        .stat_rd(stat_rd), .data_rd(data_rd), .rx_ie(rx_ie), .err_ie(err_ie),
        .modf_in(modf_in), .stat_q(stat_q), .data_q(data_q), .irq(irq)
    );

    task automatic check(input int req, input logic [STAT_W-1:0] es,
                         input logic [DATA_W-1:0] ed, input logic ei);
        total++;
        if (stat_q !== es || data_q !== ed || irq !== ei) begin
            bad++;
            $display("FAIL R%0d: stat=%h data=%h irq=%b expected stat=%h data=%h irq=%b",
                     req, stat_q, data_q, irq, es, ed, ei);
        end
    endtask

    initial begin
        rst_n = 1'b0; rx_done = 0; rx_byte = '0; stat_rd = 0; data_rd = 0;
        rx_ie = 0; err_ie = 0; modf_in = 0;
        repeat (3) @(negedge clk);
        check(9, '0, '0, 1'b0); // R9 reset state
        rst_n = 1'b1;
        for (int i = 0; i < NV; i++) begin
            {rx_done, rx_byte, stat_rd, data_rd, rx_ie, err_ie, modf_in} = VEC[i][25:12];
            @(negedge clk);
            check(int'(VEC[i][29:26]), {5'b0, VEC[i][11:9]}, VEC[i][8:1], VEC[i][0]);
        end
        // R9: reset in the middle with flags set and enables on.
        rx_done = 1'b1; rx_byte = 8'hF0; stat_rd = 0; data_rd = 0;
        rx_ie = 1; err_ie = 1; modf_in = 0;
        @(negedge clk);
        rx_done = 1'b0;
        rst_n = 1'b0;
        @(negedge clk);
        check(9, '0, '0, 1'b0); // R9 flags, data and irq cleared
        rst_n = 1'b1;
        @(negedge clk);
        check(9, '0, '0, 1'b0); // R9 stays clear after release
        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: run hung, expected completion");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule